// File: doc/BRIEF.md
# GPIO Interrupt Routing Multiplexer

This block sits between three GPIO controllers and the chip's interrupt inputs. Controller 0 supplies 14 interrupt lines, controller 1 supplies 24 and controller 2 supplies 32. The block presents 38 exclusive (direct) interrupt outputs and 3 shared outputs. A shared output is the OR of every line of one controller that is currently not given an exclusive output.

A single 32-bit control word decides the routing. Each control bit makes one pairing. Either the controller 0/1 line takes the exclusive output and the paired controller 2 line joins its controller's shared output, or the other way round. Six lines of controller 1 always have exclusive outputs of their own and never pass through the pairing.

Software sets the control word through a small memory-mapped register port. All routing paths are combinational from the GPIO inputs and the stored control word, so an interrupt reaches its output in the same cycle it arrives.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the control word is zero. It reads back as 0x00000000 at byte offset 0x54, and each direct output k for k in 0..13 follows controller 0 line k.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to 0x54 loads `cfg_wdata` into the control word at the next rising clock edge. Before that edge the old value still reads back, and after it the written value reads back on `cfg_rdata` whenever `cfg_addr` is 0x54.
- R3: A write to any other offset leaves the control word unchanged. A read at any offset other than 0x54 returns zero.
- R4: For control bit k in 0..13 cleared, direct output k carries controller 0 line k, and controller 2 line k feeds shared output 2.
- R5: For control bit k in 0..13 set, direct output k carries controller 2 line k, and controller 0 line k feeds shared output 0.
- R6: For control bit k in 14..31, controller 1 line k-14 takes the role of controller 0 in R4/R5. Cleared gives direct output k = controller 1 line k-14 and controller 2 line k on shared output 2. Set gives direct output k = controller 2 line k and controller 1 line k-14 on shared output 1.
- R7: Direct outputs 32..37 carry controller 1 lines 18..23 in order, whatever the control word holds. These lines never reach shared output 1.
- R8: Shared output i (0, 1, 2 for controllers 0, 1, 2) is the OR of that controller's lines currently in shared mode. Lines in direct mode have no effect on any shared output.
- R9: A change on a GPIO input appears on the routed output in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Byte offset of the register access |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed offset |
| c0_irq | input | 14 | Controller 0 interrupt lines |
| c1_irq | input | 24 | Controller 1 interrupt lines |
| c2_irq | input | 32 | Controller 2 interrupt lines |
| direct_irq | output | 38 | Exclusive interrupt outputs |
| shared_irq | output | 3 | Per-controller aggregated outputs |

## Verification
Every cycle, the assertions check the register behaviour: a write at the control offset loads the data, and any other cycle leaves the word stable. They also check that a shared output is never raised unless its controller has an active line, and that an all-zero control word gives controller 0 the low direct outputs with shared outputs 0 and 1 quiet. Only the bench scenarios can show the exact pairing of each control bit with its two lines. The same holds for the fixed six lines when the control word is all ones, the readback timing around the write edge, and the same-cycle propagation of a mid-cycle input change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int C0_LINES    = 14;
  localparam int C1_LINES    = 24;
  localparam int C2_LINES    = 32;
  localparam int CTRL_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int SHARED_W    = 3;
  localparam logic [ADDR_W-1:0] CTRL_OFFSET = 8'h54;

  // controller 1 lines beyond those paired by the control word
  localparam int FIXED_LINES = C1_LINES - (CTRL_W - C0_LINES);
  localparam int DIRECT_W    = CTRL_W + FIXED_LINES;

  typedef enum logic [1:0] {
    SH_CTRL0 = 2'd0,
    SH_CTRL1 = 2'd1,
    SH_CTRL2 = 2'd2
  } shared_idx_e;
endpackage

// File: rtl/gpio_irq_ctrl_reg.sv
module gpio_irq_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic              hit;
  logic              load_en;
  logic [DATA_W-1:0] ctrl_d;
  logic [DATA_W-1:0] ctrl_q;

  assign hit     = (addr_i == OFFSET);
  assign load_en = wr_en_i && hit;

  always_comb begin
    ctrl_d = ctrl_q;
    if (load_en) begin
      ctrl_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (load_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign rdata_o = hit ? ctrl_q : '0;
  assign ctrl_o  = ctrl_q;

  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFFSET) |=> (ctrl_o == $past(wdata_i)));

  p_other_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == OFFSET) |=> $stable(ctrl_o));
endmodule

// File: rtl/gpio_irq_route_slice.sv
module gpio_irq_route_slice (
  input  logic sel_i,
  input  logic home_i,
  input  logic partner_i,
  output logic direct_o,
  output logic home_shared_o,
  output logic partner_shared_o
);
  // sel clear: home line owns the exclusive output, partner is shared
  // sel set:   partner owns the exclusive output, home is shared
  always_comb begin
    if (sel_i) begin
      direct_o         = partner_i;
      home_shared_o    = home_i;
      partner_shared_o = 1'b0;
    end else begin
      direct_o         = home_i;
      home_shared_o    = 1'b0;
      partner_shared_o = partner_i;
    end
  end
endmodule

// File: rtl/gpio_irq_or_tree.sv
module gpio_irq_or_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_i,
  output logic         any_o
);
  localparam int HALF = W / 2;

  generate
    if (W == 1) begin : g_leaf
      assign any_o = in_i[0];
    end else begin : g_split
      logic lo_any;
      logic hi_any;
      gpio_irq_or_tree #(.W(HALF)) u_lo (
        .in_i  (in_i[HALF-1:0]),
        .any_o (lo_any)
      );
      gpio_irq_or_tree #(.W(W-HALF)) u_hi (
        .in_i  (in_i[W-1:HALF]),
        .any_o (hi_any)
      );
      assign any_o = lo_any | hi_any;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int N_C0   = C0_LINES,
  parameter int N_C1   = C1_LINES,
  parameter int N_C2   = C2_LINES,
  parameter int N_CTRL = CTRL_W,
  parameter int AW     = ADDR_W,
  parameter logic [AW-1:0] CTRL_ADDR = CTRL_OFFSET
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         cfg_addr,
  input  logic                  cfg_wr_en,
  input  logic [N_CTRL-1:0]     cfg_wdata,
  output logic [N_CTRL-1:0]     cfg_rdata,
  input  logic [N_C0-1:0]       c0_irq,
  input  logic [N_C1-1:0]       c1_irq,
  input  logic [N_C2-1:0]       c2_irq,
  output logic [N_CTRL+N_C1-(N_CTRL-N_C0)-1:0] direct_irq,
  output logic [SHARED_W-1:0]   shared_irq
);
  localparam int N_PAIR_C1 = N_CTRL - N_C0;
  localparam int N_FIXED   = N_C1 - N_PAIR_C1;

  logic [N_CTRL-1:0] ctrl_q;
  logic [N_CTRL-1:0] home_sh;
  logic [N_CTRL-1:0] part_sh;

  gpio_irq_ctrl_reg #(
    .ADDR_W (AW),
    .DATA_W (N_CTRL),
    .OFFSET (CTRL_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (cfg_addr),
    .wr_en_i (cfg_wr_en),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .ctrl_o  (ctrl_q)
  );

  // one routing slice per control bit
  for (genvar k = 0; k < N_CTRL; k++) begin : g_pair
    logic home_line;
    if (k < N_C0) begin : g_c0
      assign home_line = c0_irq[k];
    end else begin : g_c1
      assign home_line = c1_irq[k-N_C0];
    end
    gpio_irq_route_slice u_slice (
      .sel_i            (ctrl_q[k]),
      .home_i           (home_line),
      .partner_i        (c2_irq[k]),
      .direct_o         (direct_irq[k]),
      .home_shared_o    (home_sh[k]),
      .partner_shared_o (part_sh[k])
    );
  end

  // controller 1 lines beyond the paired range keep their own outputs
  for (genvar j = 0; j < N_FIXED; j++) begin : g_fixed
    assign direct_irq[N_CTRL+j] = c1_irq[N_PAIR_C1+j];
  end

  gpio_irq_or_tree #(.W(N_C0)) u_or_c0 (
    .in_i  (home_sh[N_C0-1:0]),
    .any_o (shared_irq[SH_CTRL0])
  );
  gpio_irq_or_tree #(.W(N_PAIR_C1)) u_or_c1 (
    .in_i  (home_sh[N_CTRL-1:N_C0]),
    .any_o (shared_irq[SH_CTRL1])
  );
  gpio_irq_or_tree #(.W(N_CTRL)) u_or_c2 (
    .in_i  (part_sh),
    .any_o (shared_irq[SH_CTRL2])
  );

  p_sh0_needs_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shared_irq[SH_CTRL0] |-> (|c0_irq));

  p_sh1_needs_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shared_irq[SH_CTRL1] |-> (|c1_irq[N_PAIR_C1-1:0]));

  p_sh2_needs_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shared_irq[SH_CTRL2] |-> ((|c2_irq) && (ctrl_q != '1)));

  p_zero_ctrl_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '0) |-> (shared_irq[SH_CTRL1:SH_CTRL0] == 2'b00 &&
                        direct_irq[N_C0-1:0] == c0_irq));
endmodule

// File: tb/gpio_irq_router_tb.sv
`timescale 1ns/1ps
module gpio_irq_router_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_wr_en;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [13:0] c0_irq;
  logic [23:0] c1_irq;
  logic [31:0] c2_irq;
  logic [37:0] direct_irq;
  logic [2:0]  shared_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  gpio_irq_router u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_addr   (cfg_addr),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .c0_irq     (c0_irq),
    .c1_irq     (c1_irq),
    .c2_irq     (c2_irq),
    .direct_irq (direct_irq),
    .shared_irq (shared_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [13:0] c0;
    logic [23:0] c1;
    logic [31:0] c2;
    logic [37:0] dir;
    logic [2:0]  sh;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // 0: R4 zero word, all controller 0 lines direct
    '{32'h0000_0000, 14'h3FFF, 24'h00_0000, 32'h0000_0000, 38'h00_0000_3FFF, 3'b000},
    // 1: R4 R8 controller 2 line 0 in shared mode
    '{32'h0000_0000, 14'h0000, 24'h00_0000, 32'h0000_0001, 38'h00_0000_0000, 3'b100},
    // 2: R5 R8 controller 0 line 0 shared when its bit is set
    '{32'hFFFF_FFFF, 14'h0001, 24'h00_0000, 32'h0000_0000, 38'h00_0000_0000, 3'b001},
    // 3: R6 controller 2 line 31 takes direct output 31
    '{32'hFFFF_FFFF, 14'h0000, 24'h00_0000, 32'h8000_0000, 38'h00_8000_0000, 3'b000},
    // 4: R7 fixed lines with zero word
    '{32'h0000_0000, 14'h0000, 24'hFC_0000, 32'h0000_0000, 38'h3F_0000_0000, 3'b000},
    // 5: R7 fixed lines with all-ones word, no shared effect
    '{32'hFFFF_FFFF, 14'h0000, 24'hFC_0000, 32'h0000_0000, 38'h3F_0000_0000, 3'b000},
    // 6: R6 bit 14 set, controller 1 line 0 shared
    '{32'h0000_4000, 14'h0000, 24'h00_0001, 32'h0000_0000, 38'h00_0000_0000, 3'b010},
    // 7: R6 mixed bits 14 and 15
    '{32'h0000_4000, 14'h0000, 24'h00_0002, 32'h0000_4000, 38'h00_0000_C000, 3'b000},
    // 8: R4 R8 bit 0 set but bit 1 clear
    '{32'h0000_0001, 14'h0002, 24'h00_0000, 32'h0000_0002, 38'h00_0000_0002, 3'b100},
    // 9: R6 bit 17 set, controller 1 line 3 shared
    '{32'h0002_0000, 14'h0000, 24'h00_0008, 32'h0000_0000, 38'h00_0000_0000, 3'b010},
    // 10: R6 R8 upper range all direct from controller 1
    '{32'h0000_0000, 14'h0000, 24'h03_FFFF, 32'hFFFF_C000, 38'h00_FFFF_C000, 3'b100}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_addr  = 8'h54;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_addr = 8'h54; cfg_wr_en = 1'b0; cfg_wdata = '0;
    c0_irq = '0; c1_irq = '0; c2_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    c0_irq = 14'h2A55;
    #1;
    chk("R1 readback", 64'(cfg_rdata), 64'h0);
    chk("R1 low direct", 64'(direct_irq[13:0]), 64'h2A55);
    chk("R1 shared", 64'(shared_irq), 64'h0);
    c0_irq = '0;

    // vector walk
    for (int i = 0; i < NV; i++) begin
      reg_write(8'h54, VECS[i].ctrl);
      c0_irq = VECS[i].c0;
      c1_irq = VECS[i].c1;
      c2_irq = VECS[i].c2;
      #1;
      chk($sformatf("R2 readback vec %0d", i), 64'(cfg_rdata), 64'(VECS[i].ctrl));
      chk($sformatf("R4/R5/R6/R7 direct vec %0d", i), 64'(direct_irq), 64'(VECS[i].dir));
      chk($sformatf("R8 shared vec %0d", i), 64'(shared_irq), 64'(VECS[i].sh));
    end
    c0_irq = '0; c1_irq = '0; c2_irq = '0;

    // R2 timing: old value visible until the edge, new one after
    reg_write(8'h54, 32'h0000_0000);
    @(negedge clk);
    cfg_addr = 8'h54; cfg_wdata = 32'hA5A5_0F0F; cfg_wr_en = 1'b1;
    #1;
    chk("R2 before edge", 64'(cfg_rdata), 64'h0);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
    chk("R2 after edge", 64'(cfg_rdata), 64'hA5A5_0F0F);

    // R3 write elsewhere ignored, read elsewhere zero
    reg_write(8'h50, 32'hFFFF_FFFF);
    #1;
    chk("R3 ctrl unchanged", 64'(cfg_rdata), 64'hA5A5_0F0F);
    cfg_addr = 8'h50;
    #1;
    chk("R3 read other offset", 64'(cfg_rdata), 64'h0);
    cfg_addr = 8'h54;
    reg_write(8'h55, 32'h0);
    #1;
    chk("R3 neighbour offset", 64'(cfg_rdata), 64'hA5A5_0F0F);

    // R9 same-cycle propagation with no clock edge in between
    reg_write(8'h54, 32'h0000_0000);
    #2;
    c0_irq = 14'h0004;
    c2_irq = 32'h0000_0010;
    #1;
    chk("R9 direct follows input", 64'(direct_irq[2]), 64'h1);
    chk("R9 shared follows input", 64'(shared_irq), 64'h4);
    c0_irq = '0;
    c2_irq = '0;
    #1;
    chk("R9 direct drops", 64'(direct_irq), 64'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule